// File: doc/BRIEF.md
# JTAG Chain-Positioning Scan Engine

This block is a host-side JTAG master. It drives the test clock, mode select, serial data and test reset into a daisy chain of TAPs, and it samples the chain's serial output. Each command runs one instruction scan or one data scan aimed at a single target TAP. All other TAPs in the chain stay in BYPASS.

Four runtime padding counts tell the engine where the target sits. For IR scans there is a bit count for the TAPs on the output side of the target and one for the TAPs on the input side. For DR scans there is a TAP count for each side, and every bypassed TAP adds one bit. The engine surrounds the target's bits with ones in IR scans, which is the BYPASS opcode for every other TAP. In DR scans it surrounds them with zero filler bits. From the output stream it keeps only the bits that came from the target.

A command is issued by pulsing a start input with the scan type, the length and the data. The block reports busy while it works and raises a one-cycle done pulse with the captured bits. The test clock is derived from the system clock by a programmable divider and rests low between scans.

Top module: `jtag_chain_scanner`

## Requirements
- R1: While reset is low, `chain_rst_n` and `chain_clk` are low and `busy` is high. After release, the engine runs one test-clock cycle with `chain_rst_n` low, then five cycles with mode 1, then one with mode 0. This brings a TAP from any state to Run-Test/Idle. `busy` then falls.
- R2: One test-clock period is 2*(`cfg_div`+1) system clocks, low half first. `chain_clk` stays low whenever `busy` is low.
- R3: `chain_mode`, `chain_sdi` and `chain_rst_n` change only when `chain_clk` falls and are stable while it is high. `chain_sdo` is sampled on the rising edge.
- R4: The mode sequence for an IR scan is 1,1,0,0. For a DR scan it is 1,0,0. Then come N shift cycles, with mode 1 only on the last one, then 1,0. The total is N = pad_out + `cmd_len` + pad_in, and the scan ends in Run-Test/Idle.
- R5: An IR scan shifts `cfg_ir_bits_out` ones, then `cmd_data` bits 0..len-1 (bit 0 first), then `cfg_ir_bits_in` ones.
- R6: A DR scan shifts `cfg_dr_taps_out` zeros, then `cmd_data` bits 0..len-1 (bit 0 first), then `cfg_dr_taps_in` zeros.
- R7: `rsp_data` bit j is the output bit sampled at shift position pad_out + j, for j < `cmd_len`. Bits at or above `cmd_len` are 0. pad_out is the out-side count of the scan's own type.
- R8: `done` is a one-cycle pulse with `busy` low. It rises 2*(`cfg_div`+1)*C system clocks after the edge that accepts the start. C is 4+N+2 for an IR scan and 3+N+2 for a DR scan.
- R9: A start while `busy` is high is ignored. A start with `cmd_len` of 0 or above DATA_W is ignored: no test clock, no `busy`, no `done`.
- R10: `rsp_data` changes only in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Half test-clock period minus one, in system clocks |
| cfg_ir_bits_out | input | PAD_W | IR bits of TAPs between target and chain output |
| cfg_ir_bits_in | input | PAD_W | IR bits of TAPs between chain input and target |
| cfg_dr_taps_out | input | PAD_W | TAP count between target and chain output |
| cfg_dr_taps_in | input | PAD_W | TAP count between chain input and target |
| cmd_start | input | 1 | Start pulse, taken when idle |
| cmd_dr | input | 1 | 1 = data scan, 0 = instruction scan |
| cmd_len | input | LEN_W | Target bit count, 1..DATA_W |
| cmd_data | input | DATA_W | Bits shifted into the target, bit 0 first |
| busy | output | 1 | Reset sequence or scan in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Bits captured from the target |
| chain_clk | output | 1 | Test clock to the chain |
| chain_mode | output | 1 | Test mode select to the chain |
| chain_sdi | output | 1 | Serial data into the chain |
| chain_rst_n | output | 1 | Test reset to the chain, active low |
| chain_sdo | input | 1 | Serial data out of the chain |

## Verification
The `done` pulse is due exactly 2*(`cfg_div`+1)*C system clocks after the accepting edge. The bench counts system-clock edges between the accepting edge and the sampling point where `done` is first seen, and requires that exact difference, which fixes when `rsp_data` becomes valid. Mode and data are checked per test-clock cycle: a TAP state model in the bench records them on every rising test-clock edge and presents the chain output on every falling edge. The expected streams and captured words are then compared position by position. Ignored starts are checked by watching `busy`, the test clock and the done count for a fixed window afterwards.

// File: rtl/jcs_pkg.sv
package jcs_pkg;

  typedef enum logic [2:0] {
    ST_TRST,
    ST_TLR,
    ST_SETTLE,
    ST_IDLE,
    ST_HEAD,
    ST_SHIFT,
    ST_UPDATE,
    ST_RETURN
  } jcs_state_e;

  localparam int TLR_CYCLES = 5;

endpackage

// File: rtl/jcs_rst_sync.sv
module jcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/jcs_tck_gen.sv
module jcs_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tck,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             tck_q, tck_n;
  logic             tick;

  assign tick     = run && (cnt_q == div);
  assign rise_evt = tick && !tck_q;
  assign fall_evt = tick && tck_q;

  always_comb begin
    cnt_n = cnt_q;
    tck_n = tck_q;
    if (!run) begin
      cnt_n = '0;
    end else if (tick) begin
      cnt_n = '0;
      tck_n = !tck_q;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      tck_q <= tck_n;
    end
  end

  assign tck = tck_q;

endmodule

// File: rtl/jcs_seq.sv
module jcs_seq
  import jcs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAD_W  = 6,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic [PAD_W-1:0]  ir_out,
  input  logic [PAD_W-1:0]  ir_in,
  input  logic [PAD_W-1:0]  dr_out,
  input  logic [PAD_W-1:0]  dr_in,
  input  logic              start,
  input  logic              is_dr,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] data,
  input  logic              sdo,
  output logic              run,
  output logic              tms,
  output logic              tdi,
  output logic              trst_n,
  output logic              done,
  output logic [DATA_W-1:0] rsp
);

  localparam int CNT_W = ((PAD_W > LEN_W) ? PAD_W : LEN_W) + 2;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO      = CNT_W'(2);
  localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(DATA_W);
  localparam logic [2:0]       TLR_LAST = 3'(TLR_CYCLES - 1);
  localparam logic [2:0]       HEAD_IR  = 3'd3;
  localparam logic [2:0]       HEAD_DR  = 3'd2;

  jcs_state_e        st_q, st_n;
  logic [2:0]        hcnt_q, hcnt_n;
  logic [CNT_W-1:0]  bit_q, bit_n;
  logic [CNT_W-1:0]  total_q, total_n;
  logic [CNT_W-1:0]  lo_q, lo_n;
  logic [CNT_W-1:0]  hi_q, hi_n;
  logic              dr_q, dr_n;
  logic [DATA_W-1:0] shreg_q, shreg_n;
  logic [DATA_W-1:0] rx_q, rx_n;
  logic [DATA_W-1:0] rsp_q, rsp_n;
  logic              tms_q, tms_n;
  logic              tdi_q, tdi_n;
  logic              trst_q, trst_n_n;
  logic              done_q, done_n;

  logic              accept;
  logic [PAD_W-1:0]  pre_sel, post_sel;
  logic [CNT_W-1:0]  pre_x, post_x, len_x;
  logic [CNT_W-1:0]  nxt_idx;
  logic              nxt_in_win;
  logic              cur_in_win;
  logic [IDX_W-1:0]  cap_idx;
  logic [2:0]        head_last;

  assign accept   = (st_q == ST_IDLE) && start && (len != '0) && (len <= MAX_LEN);
  assign pre_sel  = is_dr ? dr_out : ir_out;
  assign post_sel = is_dr ? dr_in  : ir_in;
  assign pre_x    = {{(CNT_W-PAD_W){1'b0}}, pre_sel};
  assign post_x   = {{(CNT_W-PAD_W){1'b0}}, post_sel};
  assign len_x    = {{(CNT_W-LEN_W){1'b0}}, len};

  assign nxt_idx    = (st_q == ST_SHIFT) ? (bit_q + ONE) : '0;
  assign nxt_in_win = (nxt_idx >= lo_q) && (nxt_idx < hi_q);
  assign cur_in_win = (bit_q >= lo_q) && (bit_q < hi_q);
  assign cap_idx    = IDX_W'(bit_q - lo_q);
  assign head_last  = dr_q ? HEAD_DR : HEAD_IR;

  always_comb begin
    st_n     = st_q;
    hcnt_n   = hcnt_q;
    bit_n    = bit_q;
    total_n  = total_q;
    lo_n     = lo_q;
    hi_n     = hi_q;
    dr_n     = dr_q;
    shreg_n  = shreg_q;
    rx_n     = rx_q;
    rsp_n    = rsp_q;
    tms_n    = tms_q;
    tdi_n    = tdi_q;
    trst_n_n = trst_q;
    done_n   = 1'b0;

    // target bits are taken from the chain output on the rising test-clock edge
    if (rise_evt && (st_q == ST_SHIFT) && cur_in_win) begin
      rx_n[cap_idx] = sdo;
    end

    if (st_q == ST_IDLE) begin
      if (accept) begin
        st_n    = ST_HEAD;
        hcnt_n  = '0;
        tms_n   = 1'b1;
        tdi_n   = 1'b0;
        dr_n    = is_dr;
        shreg_n = data;
        rx_n    = '0;
        lo_n    = pre_x;
        hi_n    = pre_x + len_x;
        total_n = pre_x + len_x + post_x;
      end
    end else if (fall_evt) begin
      unique case (st_q)
        ST_TRST: begin
          st_n     = ST_TLR;
          hcnt_n   = '0;
          trst_n_n = 1'b1;
          tms_n    = 1'b1;
        end
        ST_TLR: begin
          if (hcnt_q == TLR_LAST) begin
            st_n  = ST_SETTLE;
            tms_n = 1'b0;
          end else begin
            hcnt_n = hcnt_q + 3'd1;
          end
        end
        ST_SETTLE: st_n = ST_IDLE;
        ST_HEAD: begin
          if (hcnt_q == head_last) begin
            st_n  = ST_SHIFT;
            bit_n = '0;
            tms_n = (total_q == ONE);
            if (nxt_in_win) begin
              tdi_n   = shreg_q[0];
              shreg_n = shreg_q >> 1;
            end else begin
              tdi_n = !dr_q;
            end
          end else begin
            hcnt_n = hcnt_q + 3'd1;
            tms_n  = !dr_q && (hcnt_q == 3'd0);
          end
        end
        ST_SHIFT: begin
          if (bit_q == total_q - ONE) begin
            st_n  = ST_UPDATE;
            tms_n = 1'b1;
            tdi_n = 1'b0;
          end else begin
            bit_n = nxt_idx;
            tms_n = ((bit_q + TWO) == total_q);
            if (nxt_in_win) begin
              tdi_n   = shreg_q[0];
              shreg_n = shreg_q >> 1;
            end else begin
              tdi_n = !dr_q;
            end
          end
        end
        ST_UPDATE: begin
          st_n  = ST_RETURN;
          tms_n = 1'b0;
        end
        ST_RETURN: begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
          rsp_n  = rx_q;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_TRST;
      hcnt_q  <= '0;
      bit_q   <= '0;
      total_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      dr_q    <= 1'b0;
      shreg_q <= '0;
      rx_q    <= '0;
      rsp_q   <= '0;
      tms_q   <= 1'b1;
      tdi_q   <= 1'b0;
      trst_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      hcnt_q  <= hcnt_n;
      bit_q   <= bit_n;
      total_q <= total_n;
      lo_q    <= lo_n;
      hi_q    <= hi_n;
      dr_q    <= dr_n;
      shreg_q <= shreg_n;
      rx_q    <= rx_n;
      rsp_q   <= rsp_n;
      tms_q   <= tms_n;
      tdi_q   <= tdi_n;
      trst_q  <= trst_n_n;
      done_q  <= done_n;
    end
  end

  assign run    = (st_q != ST_IDLE);
  assign tms    = tms_q;
  assign tdi    = tdi_q;
  assign trst_n = trst_q;
  assign done   = done_q;
  assign rsp    = rsp_q;

endmodule

// File: rtl/jtag_chain_scanner.sv
module jtag_chain_scanner #(
  parameter int DATA_W = 32,
  parameter int PAD_W  = 6,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [PAD_W-1:0]  cfg_ir_bits_out,
  input  logic [PAD_W-1:0]  cfg_ir_bits_in,
  input  logic [PAD_W-1:0]  cfg_dr_taps_out,
  input  logic [PAD_W-1:0]  cfg_dr_taps_in,
  input  logic              cmd_start,
  input  logic              cmd_dr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rsp_data,
  output logic              chain_clk,
  output logic              chain_mode,
  output logic              chain_sdi,
  output logic              chain_rst_n,
  input  logic              chain_sdo
);

  logic srst_n;
  logic run;
  logic rise_evt;
  logic fall_evt;

  jcs_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  jcs_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk      (clk),
    .rst_n    (srst_n),
    .run      (run),
    .div      (cfg_div),
    .tck      (chain_clk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  jcs_seq #(.DATA_W(DATA_W), .PAD_W(PAD_W), .LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .ir_out   (cfg_ir_bits_out),
    .ir_in    (cfg_ir_bits_in),
    .dr_out   (cfg_dr_taps_out),
    .dr_in    (cfg_dr_taps_in),
    .start    (cmd_start),
    .is_dr    (cmd_dr),
    .len      (cmd_len),
    .data     (cmd_data),
    .sdo      (chain_sdo),
    .run      (run),
    .tms      (chain_mode),
    .tdi      (chain_sdi),
    .trst_n   (chain_rst_n),
    .done     (done),
    .rsp      (rsp_data)
  );

  assign busy = run;

endmodule

// File: rtl/jcs_checker.sv
module jcs_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rsp_data,
  input logic              chain_clk,
  input logic              chain_mode,
  input logic              chain_sdi,
  input logic              chain_rst_n
);

  // R1: test reset is only ever applied with mode select high
  assert_trst_with_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_rst_n |-> chain_mode);

  // R2: no test-clock activity outside a busy period
  assert_idle_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !chain_clk);

  // R3: chain-side outputs hold while the test clock is high
  assert_stable_high_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chain_clk |-> ($stable(chain_mode) && $stable(chain_sdi) && $stable(chain_rst_n)));

  // R8: completion is reported with the engine already idle
  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: completion lasts a single cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: the response word moves only together with done
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rsp_data));

endmodule

bind jtag_chain_scanner jcs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .rsp_data    (rsp_data),
  .chain_clk   (chain_clk),
  .chain_mode  (chain_mode),
  .chain_sdi   (chain_sdi),
  .chain_rst_n (chain_rst_n)
);

// File: tb/sim_jtag_chain_scanner.sv
`timescale 1ns/1ps
module sim_jtag_chain_scanner;

  localparam int DATA_W = 8;
  localparam int PAD_W  = 3;
  localparam int DIV_W  = 4;
  localparam int LEN_W  = $clog2(DATA_W + 1);

  typedef enum int {
    T_TLR, T_RTI, T_SEL_DR, T_CAP_DR, T_SH_DR, T_EX1_DR, T_PA_DR, T_EX2_DR, T_UPD_DR,
    T_SEL_IR, T_CAP_IR, T_SH_IR, T_EX1_IR, T_PA_IR, T_EX2_IR, T_UPD_IR
  } tap_e;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [DIV_W-1:0]  cfg_div;
  logic [PAD_W-1:0]  cfg_ir_bits_out, cfg_ir_bits_in, cfg_dr_taps_out, cfg_dr_taps_in;
  logic              cmd_start, cmd_dr;
  logic [LEN_W-1:0]  cmd_len;
  logic [DATA_W-1:0] cmd_data;
  logic              busy, done;
  logic [DATA_W-1:0] rsp_data;
  logic              chain_clk, chain_mode, chain_sdi, chain_rst_n;
  logic              chain_sdo = 1'b0;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int ndone = 0;
  int naccepted = 0;
  int seed_g = 0;

  tap_e tap = T_PA_DR;
  int   tc = 0;
  int   k = 0;
  logic last_sh_ir = 1'b0;
  logic tms_log [64];
  logic trst_log [64];
  logic tdi_log [64];

  jtag_chain_scanner #(.DATA_W(DATA_W), .PAD_W(PAD_W), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
    .cfg_ir_bits_out(cfg_ir_bits_out), .cfg_ir_bits_in(cfg_ir_bits_in),
    .cfg_dr_taps_out(cfg_dr_taps_out), .cfg_dr_taps_in(cfg_dr_taps_in),
    .cmd_start(cmd_start), .cmd_dr(cmd_dr), .cmd_len(cmd_len), .cmd_data(cmd_data),
    .busy(busy), .done(done), .rsp_data(rsp_data),
    .chain_clk(chain_clk), .chain_mode(chain_mode), .chain_sdi(chain_sdi),
    .chain_rst_n(chain_rst_n), .chain_sdo(chain_sdo)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) ndone <= ndone + 1;
  end

  function automatic tap_e tap_next(input tap_e s, input logic m);
    case (s)
      T_TLR:    return m ? T_TLR    : T_RTI;
      T_RTI:    return m ? T_SEL_DR : T_RTI;
      T_SEL_DR: return m ? T_SEL_IR : T_CAP_DR;
      T_CAP_DR: return m ? T_EX1_DR : T_SH_DR;
      T_SH_DR:  return m ? T_EX1_DR : T_SH_DR;
      T_EX1_DR: return m ? T_UPD_DR : T_PA_DR;
      T_PA_DR:  return m ? T_EX2_DR : T_PA_DR;
      T_EX2_DR: return m ? T_UPD_DR : T_SH_DR;
      T_UPD_DR: return m ? T_SEL_DR : T_RTI;
      T_SEL_IR: return m ? T_TLR    : T_CAP_IR;
      T_CAP_IR: return m ? T_EX1_IR : T_SH_IR;
      T_SH_IR:  return m ? T_EX1_IR : T_SH_IR;
      T_EX1_IR: return m ? T_UPD_IR : T_PA_IR;
      T_PA_IR:  return m ? T_EX2_IR : T_PA_IR;
      T_EX2_IR: return m ? T_UPD_IR : T_SH_IR;
      default:  return m ? T_SEL_DR : T_RTI;
    endcase
  endfunction

  function automatic logic pat(input int idx, input int sd);
    int v;
    v = idx * 13 + sd * 7;
    return v[1] ^ v[3] ^ idx[0];
  endfunction

  // chain model: records on rising test clock, presents output on falling
  always @(posedge chain_clk) begin
    if (tap == T_SH_IR || tap == T_SH_DR) begin
      if (k < 64) tdi_log[k] = chain_sdi;
      last_sh_ir = (tap == T_SH_IR);
      k = k + 1;
    end
    if (tc < 64) begin
      tms_log[tc]  = chain_mode;
      trst_log[tc] = chain_rst_n;
    end
    tc = tc + 1;
    tap = tap_next(tap, chain_mode);
    if (tap == T_CAP_IR || tap == T_CAP_DR) k = 0;
  end

  always @(negedge chain_clk) chain_sdo = pat(k, seed_g);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_scan(input bit dr, input int pre, input int post, input int len,
                          input int data, input int div, input int sd, input bit interfere);
    int s, d, n, h, c, bad_tms, bad_tdi, exp_rsp, wait_n;
    @(negedge clk);
    if (dr) begin
      cfg_dr_taps_out = PAD_W'(pre);  cfg_dr_taps_in = PAD_W'(post);
      cfg_ir_bits_out = PAD_W'(7 - pre); cfg_ir_bits_in = PAD_W'(7 - post);
    end else begin
      cfg_ir_bits_out = PAD_W'(pre);  cfg_ir_bits_in = PAD_W'(post);
      cfg_dr_taps_out = PAD_W'(7 - pre); cfg_dr_taps_in = PAD_W'(7 - post);
    end
    cfg_div  = DIV_W'(div);
    seed_g   = sd;
    tc = 0; k = 0;
    cmd_dr   = dr;
    cmd_len  = LEN_W'(len);
    cmd_data = DATA_W'(data);
    cmd_start = 1'b1;
    @(posedge clk); #1 s = cyc;
    @(negedge clk) cmd_start = 1'b0;
    naccepted++;
    if (interfere) begin
      repeat (5) @(negedge clk);
      cmd_start = 1'b1; cmd_data = ~DATA_W'(data); cmd_len = LEN_W'(1);
      @(negedge clk) cmd_start = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 5000) begin
      @(negedge clk); wait_n++;
    end
    d = cyc;
    n = pre + len + post;
    h = dr ? 3 : 4;
    c = h + n + 2;
    chk(d - s == 2 * (div + 1) * c, "R8", "done latency", d - s, 2 * (div + 1) * c);
    chk(!busy, "R8", "busy at done", busy, 0);
    chk(tc == c, "R4", "test clock cycles", tc, c);
    bad_tms = 0;
    for (int i = 0; i < c && i < 64; i++) begin
      logic e;
      if (i < h)            e = dr ? (i == 0) : (i < 2);
      else if (i < h + n)   e = (i == h + n - 1);
      else                  e = (i == h + n);
      if (tms_log[i] !== e) bad_tms++;
    end
    chk(bad_tms == 0, "R4", "mode sequence mismatches", bad_tms, 0);
    chk(tap == T_RTI, "R4", "final TAP state", tap, T_RTI);
    chk(k == n && last_sh_ir == !dr, "R4", "shift count", k, n);
    bad_tdi = 0;
    for (int i = 0; i < n && i < 64; i++) begin
      logic e;
      if (i < pre || i >= pre + len) e = !dr;
      else                           e = data[i - pre];
      if (tdi_log[i] !== e) bad_tdi++;
    end
    chk(bad_tdi == 0, dr ? "R6" : "R5", "serial data mismatches", bad_tdi, 0);
    exp_rsp = 0;
    for (int j = 0; j < len; j++) exp_rsp[j] = pat(pre + j, sd);
    chk(rsp_data == DATA_W'(exp_rsp), "R7", "captured word", rsp_data, exp_rsp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int w, n0, tc0, busy_seen;
    logic [DATA_W-1:0] rsp0;
    rst_n = 1'b0;
    cfg_div = '0; cfg_ir_bits_out = '0; cfg_ir_bits_in = '0;
    cfg_dr_taps_out = '0; cfg_dr_taps_in = '0;
    cmd_start = 1'b0; cmd_dr = 1'b0; cmd_len = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
    chk(chain_rst_n == 1'b0, "R1", "test reset during reset", chain_rst_n, 0);
    chk(chain_clk == 1'b0, "R1", "test clock during reset", chain_clk, 0);
    chk(busy == 1'b1, "R1", "busy during reset", busy, 1);
    cfg_div = DIV_W'(1);
    rst_n = 1'b1;
    w = 0;
    @(negedge clk);
    while (busy && w < 2000) begin @(negedge clk); w++; end
    chk(tc == 7, "R1", "reset sequence cycles", tc, 7);
    for (int i = 0; i < 7; i++) begin
      chk(tms_log[i] == (i < 6), "R1", "reset mode bit", tms_log[i], (i < 6));
    end
    chk(trst_log[0] == 1'b0 && trst_log[1] == 1'b1, "R1", "test reset cycle", trst_log[0], 0);
    chk(tap == T_RTI, "R1", "TAP state after reset", tap, T_RTI);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(chain_clk == 1'b0, "R2", "idle test clock", chain_clk, 0);
    end

    for (int dr = 0; dr < 2; dr++)
      for (int pre = 0; pre < 4; pre++)
        for (int post = 0; post < 4; post++)
          for (int li = 0; li < 3; li++) begin
            int len, data, div;
            len  = (li == 0) ? 1 : (li == 1) ? 5 : 8;
            data = (pre * 37 + post * 11 + li * 5 + dr * 3 + 1) & 8'hff;
            div  = (pre + 2 * post + li) % 3;
            run_scan(dr[0], pre, post, len, data, div, pre * 16 + post * 4 + li + dr,
                     (pre == 1 && post == 2));
          end

    run_scan(1'b1, 7, 7, 8, 8'hA5, 7, 3, 1'b0);
    run_scan(1'b0, 7, 0, 3, 8'h06, 0, 9, 1'b0);

    @(negedge clk);
    chk(ndone == naccepted, "R9", "done count with starts while busy", ndone, naccepted);

    // starts with an illegal length must do nothing
    for (int t = 0; t < 2; t++) begin
      n0 = ndone; tc0 = tc; rsp0 = rsp_data; busy_seen = 0;
      cmd_len = (t == 0) ? LEN_W'(0) : LEN_W'(DATA_W + 1);
      cmd_data = 8'h3C; cmd_start = 1'b1;
      @(negedge clk) cmd_start = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (busy) busy_seen++;
      end
      chk(busy_seen == 0, "R9", "busy after illegal start", busy_seen, 0);
      chk(ndone == n0, "R9", "done after illegal start", ndone, n0);
      chk(tc == tc0, "R9", "test clocks after illegal start", tc, tc0);
      chk(rsp_data == rsp0, "R10", "response held", rsp_data, rsp0);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule